// File: doc/BRIEF.md
# Multi-Byte Push UART Transmitter

This block is one serial transmit channel that hangs off a 32-bit host write bus with no byte enables. The host picks how many bytes of a written word to queue by choosing one of four push addresses. The low one, two, three or four bytes of the word then go into a transmit queue that is one word wide. Each queue entry keeps its byte count beside the data. A serializer takes the head entry apart from its lowest byte upward and sends every byte as an 8N1 frame on a line that idles high.

The bit time comes from a 16-bit phase accumulator. A rate register is added to it on every clock, and each carry out of the accumulator marks one bit boundary, so the bit rate is clk·rate/65536. The number of occupied queue entries is always visible on an output port. A write to the count address throws away the whole queue and any frame that is still going out.

Top module: `uart_push_tx`

## Requirements
- R1: After reset, txLine is high, slotCount is 0 and the rate register holds its reset value.
- R2: A write to address 0, 1, 2 or 3 queues the low 1, 2, 3 or 4 bytes of wrData, respectively, as a single entry. slotCount goes up by exactly one whatever the byte count.
- R3: slotCount reports the number of occupied entries and never exceeds DEPTH (16). A push to a full queue is dropped and leaves the queued data unchanged.
- R4: Any write to address 4 empties the queue and stops a frame in progress. In the next cycle slotCount is 0 and txLine is high.
- R5: A write to address 5 loads wrData[15:0] as the rate. Each clock adds the rate to a 16-bit accumulator, and each carry out is one bit time. A rate of 0 sends nothing.
- R6: Each byte goes out as one low start bit, eight data bits with the least significant bit first, and one high stop bit. Between frames the line is high.
- R7: The bytes of one entry are sent in the order bits 7..0, 15..8, 23..16, 31..24, up to the entry's byte count. They go back to back, each start bit following the previous stop bit directly.
- R8: An entry leaves the queue (slotCount drops by one) at the bit boundary that ends the stop bit of its last byte. The next entry's start bit begins no earlier than one bit time later.
- R9: A frame starts only at a bit boundary while the queue holds at least one entry. A push made in that same cycle counts only from the next boundary on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| wrAddr | input | 3 | Word address: 0..3 push 1..4 bytes, 4 flush, 5 rate |
| wrData | input | 32 | Host write data |
| slotCount | output | 5 | Number of occupied queue entries |
| txLine | output | 1 | Serial transmit output, idle high |

## Verification
The hardest state to reach from the ports is a full queue taking one more push. The serializer normally drains entries while the host fills them. The stimulus first sets the rate to zero, which stops every bit boundary, and then pushes eighteen entries so that the last two are refused. A flush is also issued in the middle of a frame, at a point where bits are still shifting, and a behavioural queue model confirms that the line and count recover on the next cycle.

// File: rtl/uart_push_tx_pkg.sv
package uart_push_tx_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTES    = WORD_W / 8;
  localparam int SEL_W    = $clog2(BYTES);
  localparam logic [2:0] ADDR_FLUSH = 3'd4;
  localparam logic [2:0] ADDR_RATE  = 3'd5;

  typedef struct packed {
    logic             push;
    logic [SEL_W-1:0] pushLenM1;
    logic             rateLoad;
    logic             startFrame;
    logic [SEL_W-1:0] byteSel;
    logic             shiftOut;
    logic             stopBit;
    logic             abort;
  } txStrobes_t;
endpackage

// File: rtl/uart_push_tx_ctrl.sv
module uart_push_tx_ctrl
  import uart_push_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [2:0]           wrAddr,
  input  logic                 bitTick,
  input  logic [SEL_W-1:0]     headLenM1,
  output txStrobes_t           strobes,
  output logic [PTR_W-1:0]     wrPtr,
  output logic [PTR_W-1:0]     rdPtr,
  output logic [CNT_W-1:0]     slotCount
);
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} txState_t;

  txState_t         state;
  logic [2:0]       bitCnt;
  logic [SEL_W-1:0] byteIdx;
  logic             pushReq, flushReq, rateReq, isFull, isEmpty, pushOk, popNow;

  assign pushReq  = wrEn && (wrAddr[2] == 1'b0);
  assign flushReq = wrEn && (wrAddr == ADDR_FLUSH);
  assign rateReq  = wrEn && (wrAddr == ADDR_RATE);
  assign isFull   = (slotCount == CNT_W'(DEPTH));
  assign isEmpty  = (slotCount == '0);
  assign pushOk   = pushReq && !isFull;

  always_comb begin
    strobes            = '0;
    strobes.push       = pushOk && !flushReq;
    strobes.pushLenM1  = wrAddr[SEL_W-1:0];
    strobes.rateLoad   = rateReq;
    strobes.abort      = flushReq;
    strobes.byteSel    = byteIdx;
    popNow             = 1'b0;
    if (!flushReq && bitTick) begin
      unique case (state)
        ST_IDLE:  if (!isEmpty) strobes.startFrame = 1'b1;
        ST_START: strobes.shiftOut = 1'b1;
        ST_DATA:  if (bitCnt == 3'd7) strobes.stopBit = 1'b1;
                  else strobes.shiftOut = 1'b1;
        ST_STOP:  if (byteIdx != headLenM1) begin
                    strobes.startFrame = 1'b1;
                    strobes.byteSel    = byteIdx + 1'b1;
                  end else begin
                    popNow = 1'b1;
                  end
        default: ;
      endcase
    end
  end

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      byteIdx   <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      slotCount <= '0;
    end else if (flushReq) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      byteIdx   <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      slotCount <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popNow) rdPtr <= nextPtr(rdPtr);
      slotCount <= slotCount + CNT_W'(pushOk) - CNT_W'(popNow);
      if (bitTick) begin
        unique case (state)
          ST_IDLE:  if (!isEmpty) state <= ST_START;
          ST_START: begin state <= ST_DATA; bitCnt <= '0; end
          ST_DATA:  if (bitCnt == 3'd7) state <= ST_STOP;
                    else bitCnt <= bitCnt + 1'b1;
          ST_STOP:  if (byteIdx != headLenM1) begin
                      byteIdx <= byteIdx + 1'b1;
                      state   <= ST_START;
                    end else begin
                      byteIdx <= '0;
                      state   <= ST_IDLE;
                    end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slotCount <= CNT_W'(DEPTH));
  // R4
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |=> (slotCount == '0) && (state == ST_IDLE));
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pushReq && isFull && !popNow) |=> $stable(slotCount) && $stable(wrPtr));
  // R8
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    popNow |-> !isEmpty && (state == ST_STOP));
  // R9
  start_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !bitTick && !flushReq) |=> state == ST_IDLE);
endmodule

// File: rtl/uart_push_tx_dp.sv
module uart_push_tx_dp
  import uart_push_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RATE_W = 16,
  parameter logic [RATE_W-1:0] RESET_RATE = 16'h1000,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  txStrobes_t         strobes,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [PTR_W-1:0]   rdPtr,
  input  logic [WORD_W-1:0]  wrData,
  output logic [SEL_W-1:0]   headLenM1,
  output logic               bitTick,
  output logic               txLine
);
  logic [WORD_W-1:0] memData [DEPTH];
  logic [SEL_W-1:0]  memLen  [DEPTH];
  logic [RATE_W-1:0] rateReg, acc;
  logic [RATE_W:0]   accSum;
  logic [7:0]        shiftReg, nextByte;
  logic [WORD_W-1:0] headWord;

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      memData[wrPtr] <= wrData;
      memLen[wrPtr]  <= strobes.pushLenM1;
    end
  end

  assign headWord  = memData[rdPtr];
  assign headLenM1 = memLen[rdPtr];
  assign nextByte  = headWord[8*strobes.byteSel +: 8];
  assign accSum    = {1'b0, acc} + {1'b0, rateReg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rateReg <= RESET_RATE;
      acc     <= '0;
      bitTick <= 1'b0;
    end else begin
      acc     <= accSum[RATE_W-1:0];
      bitTick <= accSum[RATE_W];
      if (strobes.rateLoad) rateReg <= wrData[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg <= '0;
      txLine   <= 1'b1;
    end else if (strobes.abort) begin
      txLine <= 1'b1;
    end else if (strobes.startFrame) begin
      shiftReg <= nextByte;
      txLine   <= 1'b0;
    end else if (strobes.shiftOut) begin
      txLine   <= shiftReg[0];
      shiftReg <= {1'b0, shiftReg[7:1]};
    end else if (strobes.stopBit) begin
      txLine <= 1'b1;
    end
  end

  // R6
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.startFrame |=> !txLine);
  // R6
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.stopBit |=> txLine);
  // R4
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.abort |=> txLine);
  // R5
  zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rateReg == '0 && acc == '0 && !strobes.rateLoad) |=> !bitTick);
endmodule

// File: rtl/uart_push_tx.sv
module uart_push_tx
  import uart_push_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RATE_W = 16,
  parameter logic [RATE_W-1:0] RESET_RATE = 16'h1000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wrEn,
  input  logic [2:0]                 wrAddr,
  input  logic [31:0]                wrData,
  output logic [$clog2(DEPTH+1)-1:0] slotCount,
  output logic                       txLine
);
  localparam int PTR_W = $clog2(DEPTH);

  txStrobes_t       strobes;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [SEL_W-1:0] headLenM1;
  logic             bitTick;

  uart_push_tx_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .bitTick(bitTick), .headLenM1(headLenM1), .strobes(strobes),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .slotCount(slotCount)
  );

  uart_push_tx_dp #(.DEPTH(DEPTH), .RATE_W(RATE_W), .RESET_RATE(RESET_RATE)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrData(wrData), .headLenM1(headLenM1), .bitTick(bitTick), .txLine(txLine)
  );
endmodule

// File: tb/uart_push_tx_tb_top.sv
module uart_push_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  slotCount;
  logic        txLine;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  uart_push_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .slotCount(slotCount), .txLine(txLine)
  );

  // behavioural reference model
  logic [31:0] qData[$];
  int          qLen[$];
  int          mState, mBit, mIdx;
  logic [7:0]  mShift;
  logic        mLine, mTick, tickNow, wasFull;
  logic [15:0] mAcc, mRate;
  logic [16:0] sum;

  function automatic logic [7:0] headByte(int idx);
    return 8'((qData[0] >> (8 * idx)) & 32'hFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      qData.delete(); qLen.delete();
      mState = 0; mBit = 0; mIdx = 0; mShift = '0; mLine = 1'b1;
      mTick = 1'b0; mAcc = '0; mRate = 16'h1000;
    end else begin
      tickNow = mTick;
      wasFull = (qData.size() == 16);
      sum = {1'b0, mAcc} + {1'b0, mRate};
      mTick = sum[16];
      mAcc = sum[15:0];
      if (wrEn && wrAddr == 3'd5) mRate = wrData[15:0];
      if (wrEn && wrAddr == 3'd4) begin
        qData.delete(); qLen.delete();
        mState = 0; mIdx = 0; mLine = 1'b1;
      end else begin
        if (tickNow) begin
          case (mState)
            0: if (qData.size() > 0) begin
                 mState = 1; mIdx = 0; mShift = headByte(0); mLine = 1'b0;
               end
            1: begin mState = 2; mBit = 0; mLine = mShift[0]; mShift = mShift >> 1; end
            2: if (mBit == 7) begin mState = 3; mLine = 1'b1; end
               else begin mBit++; mLine = mShift[0]; mShift = mShift >> 1; end
            default: if (mIdx != qLen[0] - 1) begin
                       mIdx++; mState = 1; mShift = headByte(mIdx); mLine = 1'b0;
                     end else begin
                       void'(qData.pop_front()); void'(qLen.pop_front());
                       mIdx = 0; mState = 0;
                     end
          endcase
        end
        if (wrEn && wrAddr < 3'd4 && !wasFull) begin
          qData.push_back(wrData);
          qLen.push_back(int'(wrAddr) + 1);
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (txLine !== mLine) begin
        bad++;
        $display("FAIL %s txLine actual=%0b expected=%0b t=%0t", curReq, txLine, mLine, $time);
      end
      checks++;
      if (slotCount !== 5'(qData.size())) begin
        bad++;
        $display("FAIL %s slotCount actual=%0d expected=%0d t=%0t", curReq, slotCount, qData.size(), $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic expectNow(input string req, input int cnt, input logic line);
    checks++;
    if (slotCount !== 5'(cnt) || txLine !== line) begin
      bad++;
      $display("FAIL %s count/line actual=%0d/%0b expected=%0d/%0b", req, slotCount, txLine, cnt, line);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 40000; i++) begin
      if (qData.size() == 0 && mState == 0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle line, empty queue
    expectNow("R1", 0, 1'b1);

    // R2 R6: single byte frame at a fast rate
    curReq = "R6";
    hostWrite(3'd5, 32'h0000_8000);
    hostWrite(3'd0, 32'hFFFF_FFA5);
    expectNow("R2", 1, 1'b1);
    drain();

    // R7 R2: multi-byte entries sent low byte first, back to back
    curReq = "R7";
    hostWrite(3'd3, 32'h4433_2211);
    hostWrite(3'd1, 32'h0000_C33C);
    hostWrite(3'd2, 32'h00F0_0F81);
    drain();

    // R5: odd rate, accumulator phase carries across bits
    curReq = "R5";
    hostWrite(3'd5, 32'h0000_1234);
    hostWrite(3'd1, 32'hABCD_5A96);
    drain();

    // R3: freeze the line with rate 0, overfill the queue
    curReq = "R3";
    hostWrite(3'd5, 32'h0000_0000);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 18; k++) hostWrite(3'(k % 4), 32'h1000_0000 + k);
    expectNow("R3", 16, 1'b1);
    // R4: flush a full queue
    curReq = "R4";
    hostWrite(3'd4, 32'h0);
    expectNow("R4", 0, 1'b1);

    // R4: flush mid-frame
    hostWrite(3'd5, 32'h0000_2000);
    hostWrite(3'd3, 32'h0000_0000);
    repeat (60) @(negedge clk);
    hostWrite(3'd4, 32'h0);
    expectNow("R4", 0, 1'b1);
    repeat (40) @(negedge clk);

    // R8 R9: several entries, gap between entries, push races a tick
    curReq = "R8";
    hostWrite(3'd5, 32'h0000_4000);
    hostWrite(3'd0, 32'h0000_0001);
    hostWrite(3'd0, 32'h0000_0080);
    curReq = "R9";
    hostWrite(3'd1, 32'h0000_55AA);
    repeat (7) @(negedge clk);
    hostWrite(3'd0, 32'h0000_00FE);
    drain();
    repeat (20) @(negedge clk);
    expectNow("R8", 0, 1'b1);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule